// File: doc/BRIEF.md
# First-Word Fall-Through Single-Clock FIFO

This block is a single-clock queue whose width and depth are parameters. The oldest stored word is always visible on the read data output. A consumer therefore looks at the data while the empty flag is low and pulses read enable only to retire that word. Producers push with write enable and must respect the full flag. Any request that the flags forbid is dropped and has no effect.

Storage is a small register array written on the clock and read without a register, so it can map onto distributed RAM. Full and empty are decoded from an occupancy counter that sits beside the two wrapping pointers. A read and a write in the same cycle leave the count unchanged. When the queue is full, a write paired with a read still lands, because the read frees a slot on the same edge.

Top module: `fwft_fifo`

## Requirements
- R1: While rst_ni is low, and after it is released, the queue is empty: empty_o=1 and full_o=0.
- R2: Whenever empty_o is 0, rd_data_o carries the oldest stored word without any read request. empty_o falls on the clock edge that stores the first word into an empty queue.
- R3: Words leave in the order they were accepted, and none is lost or repeated.
- R4: A write while full_o=1 and rd_en_i=0 is dropped. full_o stays 1, rd_data_o is unchanged, and the stored contents are untouched.
- R5: A read while empty_o=1 is dropped. With no write in the same cycle, empty_o stays 1 and no later word is skipped.
- R6: A read and a write accepted together when the queue is neither empty nor full leave empty_o and full_o unchanged, and both pointers advance.
- R7: With full_o=1, a write paired with a read is accepted. full_o stays 1 and the new word comes out after the older ones.
- R8: With empty_o=1, a write paired with a read stores the word, the read is ignored, and that word is on rd_data_o one cycle later.
- R9: full_o is 1 exactly when DEPTH words are held, and empty_o is 1 exactly when none are. Pointers wrap modulo DEPTH, which must be a power of two.
- R10: While empty_o=0 and rd_en_i=0, rd_data_o and empty_o hold from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Push request |
| wr_data_i | input | DATA_W | Word to push |
| rd_en_i | input | 1 | Retire the head word |
| rd_data_o | output | DATA_W | Head word, valid while empty_o is 0 |
| full_o | output | 1 | DEPTH words held |
| empty_o | output | 1 | No word held |

## Verification
The first pattern fills the queue with a write burst and then drains it with a read burst. This shows whether the flags switch at exactly zero and DEPTH entries, and whether the order survives a pointer wrap. Directed single cycles then hit the four edge cases of one side alone or both together, at full and at empty. These separate a correct pass-through of a write at full from a wrongly dropped one, and an ignored read at empty from a consumed one. A long run of randomly interleaved pushes and pops, at several fill levels, is checked against a reference queue. That run exposes miscounting when reads and writes land on the same edge.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;
  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  typedef enum logic [1:0] {
    OCC_HOLD = 2'b00,
    OCC_DEC  = 2'b01,
    OCC_INC  = 2'b10,
    OCC_BOTH = 2'b11
  } occ_op_e;
endpackage

// File: rtl/fwft_fifo_mem.sv
module fwft_fifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned ADDR_W = fwft_fifo_pkg::addr_bits(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] store_q [DEPTH];

  // no reset: keeps the array mappable to LUT RAM
  always_ff @(posedge clk_i) begin
    if (we_i) store_q[waddr_i] <= wdata_i;
  end

  // unregistered read gives fall-through head
  assign rdata_o = store_q[raddr_i];
endmodule

// File: rtl/fwft_fifo_ptr.sv
module fwft_fifo_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned ADDR_W = fwft_fifo_pkg::addr_bits(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  // power-of-two depth: natural overflow is the modulo wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_q + ADDR_W'(1);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/fwft_fifo_occ.sv
module fwft_fifo_occ #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned ADDR_W = fwft_fifo_pkg::addr_bits(DEPTH),
  localparam int unsigned CNT_W  = ADDR_W + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic full_o,
  output logic empty_o
);
  import fwft_fifo_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  occ_op_e          op;

  assign op = occ_op_e'({inc_i, dec_i});

  always_comb begin
    cnt_d = cnt_q;
    unique case (op)
      OCC_INC: cnt_d = cnt_q + CNT_W'(1);
      OCC_DEC: cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned ADDR_W = fwft_fifo_pkg::addr_bits(DEPTH);

  logic              push, pop;
  logic [ADDR_W-1:0] wptr, rptr;

  // a read at full frees the slot the write takes
  assign pop  = rd_en_i && !empty_o;
  assign push = wr_en_i && (!full_o || pop);

  fwft_fifo_ptr #(.DEPTH(DEPTH)) i_wptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(push), .ptr_o(wptr)
  );

  fwft_fifo_ptr #(.DEPTH(DEPTH)) i_rptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(pop), .ptr_o(rptr)
  );

  fwft_fifo_occ #(.DEPTH(DEPTH)) i_occ (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(push), .dec_i(pop),
    .full_o(full_o), .empty_o(empty_o)
  );

  fwft_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_mem (
    .clk_i(clk_i), .we_i(push), .waddr_i(wptr), .wdata_i(wr_data_i),
    .raddr_i(rptr), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/fwft_fifo_chk.sv
module fwft_fifo_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              full_o,
  input logic              empty_o
);
  // R9
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_en_i && !rd_en_i |=> full_o && $stable(rd_data_o));

  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !wr_en_i |=> empty_o);

  // R7
  full_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_en_i && rd_en_i |=> full_o);

  // R8
  empty_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && wr_en_i |=> !empty_o);

  // R6
  mid_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o && !full_o && wr_en_i && rd_en_i |=> $stable(empty_o) && $stable(full_o));

  // R10
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o && !rd_en_i |=> !empty_o && $stable(rd_data_o));
endmodule

bind fwft_fifo fwft_fifo_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .rd_data_o(rd_data_o), .full_o(full_o), .empty_o(empty_o)
);

// File: tb/test_fwft_fifo.sv
module test_fwft_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic              full_o, empty_o;

  int n_chk = 0, n_bad = 0;
  logic [DATA_W-1:0] exp_q [$];
  event sample_ev;
  logic [DATA_W-1:0] seq_val = 8'h10;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fwft_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .full_o(full_o), .empty_o(empty_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: flags vs model, head vs queue front, pop on accepted read
  initial forever begin
    @(sample_ev);
    chk(empty_o == (exp_q.size() == 0), "R9 empty", empty_o, exp_q.size() == 0);
    chk(full_o == (exp_q.size() == DEPTH), "R9 full", full_o, exp_q.size() == DEPTH);
    if (exp_q.size() > 0) begin
      chk(rd_data_o == exp_q[0], "R3 head", rd_data_o, exp_q[0]);
      if (rd_en_i) void'(exp_q.pop_front());
    end
  end

  // driver: one cycle of stimulus; pushes expected item when write accepted
  task automatic step(input bit wr, input bit rd, input logic [DATA_W-1:0] d);
    bit rd_acc, wr_acc;
    @(negedge clk);
    wr_en_i = wr; rd_en_i = rd; wr_data_i = d;
    #1;
    rd_acc = rd && exp_q.size() > 0;
    wr_acc = wr && (exp_q.size() < DEPTH || rd_acc);
    ->sample_ev;
    #1;
    if (wr_acc) exp_q.push_back(d);
  endtask

  task automatic settle();
    @(negedge clk); wr_en_i = 0; rd_en_i = 0; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] h;
    #(CLK_PERIOD*2 + 1);
    // R1
    chk(empty_o == 1 && full_o == 0, "R1 in reset", {full_o, empty_o}, 2'b01);
    @(negedge clk); rst_ni = 1'b1;
    settle();
    chk(empty_o == 1 && full_o == 0, "R1 after reset", {full_o, empty_o}, 2'b01);

    // R2: first word falls through
    step(1, 0, 8'hA5); settle();
    chk(empty_o == 0, "R2 empty drop", empty_o, 0);
    chk(rd_data_o == 8'hA5, "R2 head", rd_data_o, 8'hA5);
    // R10: head holds while idle
    repeat (3) step(0, 0, 8'h00);
    settle();
    chk(rd_data_o == 8'hA5 && !empty_o, "R10 hold", rd_data_o, 8'hA5);

    // burst fill to full, R9
    for (int i = 1; i < DEPTH; i++) step(1, 0, seq_val++);
    settle();
    chk(full_o == 1, "R9 full at DEPTH", full_o, 1);
    // R4: write at full dropped
    step(1, 0, 8'hEE); settle();
    chk(full_o == 1 && rd_data_o == 8'hA5, "R4 drop", rd_data_o, 8'hA5);
    // R7: read+write at full
    step(1, 1, 8'h77); settle();
    chk(full_o == 1, "R7 full kept", full_o, 1);
    chk(exp_q[DEPTH-1] == 8'h77, "R7 tail", exp_q[DEPTH-1], 8'h77);

    // burst drain, R3 via monitor; R9 empty at zero
    repeat (DEPTH) step(0, 1, 8'h00);
    settle();
    chk(empty_o == 1, "R9 empty after drain", empty_o, 1);
    // R5: read at empty dropped
    step(0, 1, 8'h00); step(0, 1, 8'h00); settle();
    chk(empty_o == 1, "R5 stays empty", empty_o, 1);
    // R8: read+write at empty
    step(1, 1, 8'h3C); settle();
    chk(empty_o == 0 && rd_data_o == 8'h3C, "R8 fill", rd_data_o, 8'h3C);
    // R6: mid-level read+write
    step(1, 0, 8'h4D); step(1, 0, 8'h5E); settle();
    step(1, 1, 8'h6F); settle();
    chk(!empty_o && !full_o && rd_data_o == 8'h4D, "R6 both", rd_data_o, 8'h4D);
    h = rd_data_o;
    step(0, 0, 8'h00); settle();
    chk(rd_data_o == h, "R10 hold mid", rd_data_o, h);

    // random interleaving, bias changing to visit all fill levels
    for (int i = 0; i < 3000; i++) begin
      int bias;
      bias = (i / 300) % 3;
      step(($urandom % 4) < 1 + bias, ($urandom % 4) < 3 - bias, 8'($urandom));
    end
    repeat (DEPTH + 1) step(0, 1, 8'h00);
    settle();
    chk(empty_o == 1, "R9 final drain", empty_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule